// File: doc/BRIEF.md
# SPI Flash Read Engine

This block converts read requests arriving on a simple memory-mapped request port into read transactions on a single-data-line SPI flash. A transaction opens with slave select low and a header (an optional read opcode, then a 24-bit address, most significant byte first), after which data bytes are shifted in from the device and returned one per cycle with a valid strobe. A done strobe accompanies the last byte of every request.

The block keeps track of the address the device will present next. Before each byte it compares that address with the one the request needs. On a match the byte is read in the open transaction. On a mismatch slave select is released and a new header is sent. The same rule covers three cases: sequential bursts, cache-line fills that start in the middle of a 32-byte line and return their bytes in wrapped order, and back-to-back sequential requests. Three configuration inputs shape the header and the slave-select handling. One drops the opcode for execute-in-place use. One tells the block that the device wraps its internal address within 32-byte lines. One keeps the transaction open between requests so that a sequential follow-on request can continue it.

Top module: `spi_flash_reader`

## Requirements
- R1: With `cfg_skip_cmd` low, each header is the opcode byte (parameter `OPCODE`, default 0x03) followed by the 3 address bytes, high byte first; every byte is sent most significant bit first.
- R2: With `cfg_skip_cmd` high, the header is only the 3 address bytes; the first bit after slave select falls is address bit 23.
- R3: SPI mode 0: `spi_sck` is low whenever `spi_cs_n` is high, `spi_mosi` changes only while `spi_sck` is low, and `spi_miso` is sampled at the rising edge of `spi_sck`, most significant bit first.
- R4: Every high phase of `spi_sck` lasts exactly DIV/2 system clock cycles (DIV is an even parameter of at least 2, default 4).
- R5: With `req_fill` low, a request returns bytes from strictly ascending addresses. If `cfg_wrap_line` is high and the burst crosses a 32-byte aligned boundary, slave select is released and a new header carrying the boundary address is sent.
- R6: With `req_fill` high and `cfg_wrap_line` high, a request returns bytes in wrapped order within the 32-byte line that holds `req_addr`, in a single transaction with one header.
- R7: With `req_fill` high and `cfg_wrap_line` low, the data wraps within the line in the same way, but the block reopens the transaction with a header at the line base when the line end is reached.
- R8: With `cfg_merge` high, slave select stays low after a request completes. A next request whose address equals the device's next address continues the transaction with no new header.
- R9: Before any new header, `spi_cs_n` stays high for at least DIV system clock cycles.
- R10: `rd_valid` pulses once per returned byte, with the byte on `rd_data`. `rd_done` pulses exactly once per request, in the same cycle as the last byte's `rd_valid`.
- R11: `req_ready` is high only when the block is idle or is holding a merged transaction open, and never during a transfer. Lowering `cfg_merge` while a transaction is held open releases slave select.
- R12: After reset, `spi_cs_n` is high, `spi_sck` is low, `rd_valid` and `rd_done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_skip_cmd | input | 1 | Omit the opcode from headers (device already primed) |
| cfg_wrap_line | input | 1 | Device address wraps within 32-byte lines |
| cfg_merge | input | 1 | Keep the transaction open between requests |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 24 | Byte address of the first byte wanted |
| req_len | input | 6 | Byte count, 1 to 32 |
| req_fill | input | 1 | Cache-line fill: wrapped order within the line |
| rd_valid | output | 1 | Data byte strobe |
| rd_data | output | 8 | Returned byte |
| rd_done | output | 1 | Last byte of the request |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Slave select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The hardest situation to reach is a resumed transaction. Slave select was held through an idle pause, and the device has already put out the first bit of the next byte on the final falling edge of the previous one. Only a bus-level flash model that follows the device's own address increment can show whether the block picks up exactly that bit. The stimulus first sets merge and issues two back-to-back sequential requests, then a non-sequential one. Separately, misaligned line fills near the end of a line run with wrap both on and off, so that both the in-transaction wrap and the reopen at the line base occur.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_XFER,
        ST_OPEN
    } rd_state_e;
endpackage

// File: rtl/spi_rd_tick.sv
module spi_rd_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        tick = en && (cnt_q == CW'(HALF - 1));
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_rd_addr_step.sv
module spi_rd_addr_step #(
    parameter int AW         = 24,
    parameter int LINE_BYTES = 32
) (
    input  logic [AW-1:0] cur,
    input  logic          in_line,
    output logic [AW-1:0] nxt
);
    localparam int LB = $clog2(LINE_BYTES);

    always_comb begin
        if (in_line) nxt = {cur[AW-1:LB], LB'(cur[LB-1:0] + LB'(1))};
        else         nxt = cur + AW'(1);
    end
endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader
    import spi_rd_pkg::*;
#(
    parameter int         DIV        = 4,
    parameter int         ADDR_BYTES = 3,
    parameter int         MAX_LEN    = 32,
    parameter int         LINE_BYTES = 32,
    parameter logic [7:0] OPCODE     = 8'h03,
    localparam int        AW         = 8 * ADDR_BYTES,
    localparam int        LENW       = $clog2(MAX_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_skip_cmd,
    input  logic            cfg_wrap_line,
    input  logic            cfg_merge,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  logic [LENW-1:0] req_len,
    input  logic            req_fill,
    output logic            rd_valid,
    output logic [7:0]      rd_data,
    output logic            rd_done,
    output logic            spi_sck,
    output logic            spi_cs_n,
    output logic            spi_mosi,
    input  logic            spi_miso
);
    localparam int HALF = DIV / 2;
    localparam int HW   = $clog2(ADDR_BYTES + 2);

    typedef struct packed {
        rd_state_e       st;
        logic            cs_n;
        logic            sck;
        logic [7:0]      tx;
        logic [7:0]      rx;
        logic [2:0]      bitn;
        logic [HW-1:0]   hdr;
        logic            gap;
        logic [AW-1:0]   addr;
        logic [AW-1:0]   dev;
        logic [LENW-1:0] left;
        logic            fill;
        logic            busy;
        logic            skip;
        logic            wrap;
        logic            merge;
        logic            rvalid;
        logic            rdone;
        logic [7:0]      rdata;
    } eng_t;

    eng_t q, d;

    logic          tick;
    logic [AW-1:0] dev_nx;
    logic [AW-1:0] need_nx;

    spi_rd_tick #(.HALF(HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    ((q.st == ST_XFER) || (q.st == ST_GAP)),
        .tick  (tick)
    );

    // where the device will be after the current byte
    spi_rd_addr_step #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_dev_step (
        .cur     (q.addr),
        .in_line (q.wrap),
        .nxt     (dev_nx)
    );

    // which byte the request wants after the current one
    spi_rd_addr_step #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_need_step (
        .cur     (q.addr),
        .in_line (q.fill),
        .nxt     (need_nx)
    );

    function automatic logic [7:0] hdr_byte(input logic [HW-1:0] k, input logic [AW-1:0] a);
        if (k > HW'(ADDR_BYTES)) return OPCODE;
        return 8'(a >> (8 * (int'(k) - 1)));
    endfunction

    always_comb begin
        logic start;
        start    = 1'b0;
        d        = q;
        d.rvalid = 1'b0;
        d.rdone  = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.left  = req_len;
                    d.fill  = req_fill;
                    d.busy  = 1'b1;
                    d.skip  = cfg_skip_cmd;
                    d.wrap  = cfg_wrap_line;
                    d.merge = cfg_merge;
                    start   = 1'b1;
                end
            end

            ST_GAP: begin
                if (tick) begin
                    if (!q.gap) begin
                        d.gap = 1'b1;
                    end else begin
                        d.gap = 1'b0;
                        if (q.busy) start = 1'b1;
                        else        d.st  = ST_IDLE;
                    end
                end
            end

            ST_XFER: begin
                if (tick) begin
                    if (!q.sck) begin
                        d.sck = 1'b1;
                        d.rx  = {q.rx[6:0], spi_miso};
                    end else begin
                        d.sck = 1'b0;
                        if (q.bitn != 3'd7) begin
                            d.bitn = q.bitn + 3'd1;
                            d.tx   = {q.tx[6:0], 1'b0};
                        end else begin
                            d.bitn = 3'd0;
                            d.tx   = 8'h00;
                            if (q.hdr > HW'(1)) begin
                                d.hdr = q.hdr - HW'(1);
                                d.tx  = hdr_byte(q.hdr - HW'(1), q.addr);
                            end else if (q.hdr == HW'(1)) begin
                                d.hdr = '0;
                                d.dev = q.addr;
                            end else begin
                                d.rvalid = 1'b1;
                                d.rdata  = q.rx;
                                d.dev    = dev_nx;
                                if (q.left == LENW'(1)) begin
                                    d.rdone = 1'b1;
                                    d.busy  = 1'b0;
                                    d.left  = '0;
                                    if (q.merge) begin
                                        d.st = ST_OPEN;
                                    end else begin
                                        d.st   = ST_GAP;
                                        d.cs_n = 1'b1;
                                        d.gap  = 1'b0;
                                    end
                                end else begin
                                    d.left = q.left - LENW'(1);
                                    d.addr = need_nx;
                                    if (need_nx != dev_nx) begin
                                        d.st   = ST_GAP;
                                        d.cs_n = 1'b1;
                                        d.gap  = 1'b0;
                                    end
                                end
                            end
                        end
                    end
                end
            end

            ST_OPEN: begin
                if (!cfg_merge) begin
                    d.st   = ST_GAP;
                    d.cs_n = 1'b1;
                    d.gap  = 1'b0;
                end else if (req_valid) begin
                    d.addr = req_addr;
                    d.left = req_len;
                    d.fill = req_fill;
                    d.busy = 1'b1;
                    if (req_addr == q.dev) begin
                        d.st   = ST_XFER;
                        d.hdr  = '0;
                        d.bitn = 3'd0;
                        d.tx   = 8'h00;
                    end else begin
                        d.st   = ST_GAP;
                        d.cs_n = 1'b1;
                        d.gap  = 1'b0;
                    end
                end
            end

            default: d.st = ST_IDLE;
        endcase

        if (start) begin
            d.st   = ST_XFER;
            d.cs_n = 1'b0;
            d.sck  = 1'b0;
            d.bitn = 3'd0;
            d.hdr  = d.skip ? HW'(ADDR_BYTES) : HW'(ADDR_BYTES + 1);
            d.tx   = hdr_byte(d.hdr, d.addr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE) || ((q.st == ST_OPEN) && cfg_merge);
    assign rd_valid  = q.rvalid;
    assign rd_data   = q.rdata;
    assign rd_done   = q.rdone;
    assign spi_sck   = q.sck;
    assign spi_cs_n  = q.cs_n;
    assign spi_mosi  = q.tx[7];
endmodule

// File: rtl/spi_flash_reader_chk.sv
module spi_flash_reader_chk #(
    parameter int DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rd_valid,
    input logic rd_done,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_mosi
);
    localparam int CNTW = $clog2(DIV + 1) + 1;

    logic [CNTW-1:0] cs_hi;
    logic [CNTW-1:0] sck_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_hi  <= CNTW'(DIV);
            sck_hi <= '0;
        end else begin
            if (!spi_cs_n)                cs_hi <= '0;
            else if (cs_hi < CNTW'(DIV))  cs_hi <= cs_hi + CNTW'(1);
            if (spi_sck) sck_hi <= sck_hi + CNTW'(1);
            else         sck_hi <= '0;
        end
    end

    assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    assert_sck_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_sck) |-> (sck_hi == CNTW'(DIV / 2)));

    assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (cs_hi >= CNTW'(DIV)));

    assert_done_with_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> rd_valid);

    assert_ready_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !spi_sck);
endmodule

bind spi_flash_reader spi_flash_reader_chk #(.DIV(DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .rd_done   (rd_done),
    .spi_sck   (spi_sck),
    .spi_cs_n  (spi_cs_n),
    .spi_mosi  (spi_mosi)
);

// File: tb/spi_flash_reader_test.sv
`timescale 1ns/1ps
module spi_flash_reader_test;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_skip_cmd = 1'b0, cfg_wrap_line = 1'b0, cfg_merge = 1'b0;
    logic        req_valid = 1'b0, req_fill = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [5:0]  req_len = '0;
    logic        rd_valid, rd_done;
    logic [7:0]  rd_data;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    always #2.5 clk = ~clk;

    spi_flash_reader #(.DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_skip_cmd(cfg_skip_cmd), .cfg_wrap_line(cfg_wrap_line), .cfg_merge(cfg_merge),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_fill(req_fill),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_f(input logic [23:0] a);
        return a[7:0] ^ {a[15:11], a[18:16]} ^ 8'h5A;
    endfunction

    function automatic logic [23:0] exp_addr(input logic [23:0] s, input int k, input logic fill);
        if (fill) return {s[23:5], 5'(s[4:0] + 5'(k))};
        return s + 24'(k);
    endfunction

    // flash model: header in on rising edges, data out on falling edges
    logic [31:0] m_sh;
    int          m_bits, m_bi, hdr_n = 0, bad_op = 0;
    logic        m_data;
    logic [23:0] m_ptr;
    logic [7:0]  m_cur;

    always @(negedge spi_cs_n) begin
        m_bits = 0; m_bi = 0; m_data = 1'b0;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n && !m_data) begin
            m_sh = {m_sh[30:0], spi_mosi};
            m_bits++;
            if (m_bits == (cfg_skip_cmd ? 24 : 32)) begin
                m_data = 1'b1;
                hdr_n++;
                if (!cfg_skip_cmd && m_sh[31:24] != 8'h03) bad_op++;
                m_ptr = m_sh[23:0];
                m_bi  = 0;
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && m_data) begin
            if (m_bi == 0) begin
                m_cur = mem_f(m_ptr);
                m_ptr = cfg_wrap_line ? {m_ptr[23:5], 5'(m_ptr[4:0] + 5'd1)} : m_ptr + 24'd1;
            end
            spi_miso = m_cur[7 - m_bi];
            m_bi = (m_bi + 1) % 8;
        end
    end

    // port monitors
    logic [7:0] rx_buf [0:63];
    int rx_n = 0, done_n = 0;
    int sck_hi = 0, sck_bad = 0, sck_rises = 0, mosi_bad = 0, cs_hi = 0, min_gap = 1000;
    logic prev_sck = 1'b0, prev_mosi = 1'b0;

    always @(negedge clk) begin
        if (rd_valid) begin
            if (rx_n < 64) rx_buf[rx_n] = rd_data;
            rx_n++;
        end
        if (rd_done) done_n++;
        if (spi_sck) sck_hi++;
        else begin
            if (sck_hi != 0) begin
                sck_rises++;
                if (sck_hi != DIV / 2) sck_bad++;
            end
            sck_hi = 0;
        end
        if (spi_sck && prev_sck && spi_mosi != prev_mosi) mosi_bad++;
        prev_sck = spi_sck; prev_mosi = spi_mosi;
        if (spi_cs_n) cs_hi++;
        else begin
            if (cs_hi != 0 && cs_hi < min_gap) min_gap = cs_hi;
            cs_hi = 0;
        end
    end

    task automatic issue(input logic [23:0] a, input int n, input logic fill);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = 6'(n); req_fill = fill;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int target);
        int t = 0;
        while (done_n < target && t < 8000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic check_bytes(input logic [23:0] a, input int n, input logic fill, input string req);
        chk(rx_n == n, req, rx_n, n);
        for (int k = 0; k < n && k < 64; k++)
            chk(rx_buf[k] == mem_f(exp_addr(a, k, fill)), req, rx_buf[k], mem_f(exp_addr(a, k, fill)));
    endtask

    typedef struct packed {
        logic [23:0] a;
        logic [5:0]  n;
        logic        fill;
        logic        skip;
        logic        wrap;
        logic [2:0]  hdrs;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VT [NV] = '{
        '{24'h000100, 6'd4,  1'b0, 1'b0, 1'b0, 3'd1},  // R1 plain burst
        '{24'h00011C, 6'd8,  1'b0, 1'b0, 1'b0, 3'd1},  // R5 crossing, no wrap
        '{24'h00011C, 6'd8,  1'b0, 1'b0, 1'b1, 3'd2},  // R5 crossing with wrap: reopen
        '{24'h000214, 6'd32, 1'b1, 1'b0, 1'b1, 3'd1},  // R6 misaligned fill, one header
        '{24'h000214, 6'd32, 1'b1, 1'b0, 1'b0, 3'd2},  // R7 fill reopens at line base
        '{24'h123456, 6'd3,  1'b0, 1'b1, 1'b0, 3'd1},  // R2 opcode skipped
        '{24'h0003E0, 6'd32, 1'b0, 1'b0, 1'b1, 3'd1},  // R5 aligned full line
        '{24'hFFFFFE, 6'd4,  1'b0, 1'b0, 1'b0, 3'd1},  // R5 address roll-over
        '{24'h00043F, 6'd1,  1'b1, 1'b0, 1'b1, 3'd1},  // R10 single byte
        '{24'h00051A, 6'd20, 1'b1, 1'b1, 1'b1, 3'd1},  // R2 R6 skip plus wrap fill
        '{24'h00013C, 6'd8,  1'b0, 1'b1, 1'b1, 3'd2}   // R2 R5 skip with reopen
    };

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", done_n, -1);
        summary();
        $finish;
    end

    initial begin
        int h, d0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(spi_cs_n == 1'b1, "R12 cs_n", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R12 sck", spi_sck, 0);
        chk(rd_valid == 1'b0 && rd_done == 1'b0, "R12 strobes", {rd_valid, rd_done}, 0);
        chk(req_ready == 1'b1, "R12 ready", req_ready, 1);

        for (int i = 0; i < NV; i++) begin
            cfg_skip_cmd = VT[i].skip; cfg_wrap_line = VT[i].wrap; cfg_merge = 1'b0;
            repeat (4) @(negedge clk);
            h = hdr_n; d0 = done_n; rx_n = 0;
            issue(VT[i].a, int'(VT[i].n), VT[i].fill);
            wait_done(d0 + 1);
            repeat (20) @(negedge clk);
            check_bytes(VT[i].a, int'(VT[i].n), VT[i].fill, "R1 R2 R5 R6 R7 data");
            chk(hdr_n - h == int'(VT[i].hdrs), "R5 R6 R7 header count", hdr_n - h, VT[i].hdrs);
            chk(done_n - d0 == 1, "R10 done count", done_n - d0, 1);
        end

        // merged sequential requests
        cfg_skip_cmd = 1'b0; cfg_wrap_line = 1'b0; cfg_merge = 1'b1;
        repeat (4) @(negedge clk);
        h = hdr_n; rx_n = 0;
        issue(24'h000600, 4, 1'b0);
        repeat (8) @(negedge clk);
        chk(req_ready == 1'b0, "R11 ready low in transfer", req_ready, 0);
        wait_done(done_n + 1);
        repeat (20) @(negedge clk);
        check_bytes(24'h000600, 4, 1'b0, "R8 first");
        chk(spi_cs_n == 1'b0, "R8 select held", spi_cs_n, 0);
        chk(req_ready == 1'b1, "R11 ready when open", req_ready, 1);
        rx_n = 0; d0 = done_n;
        issue(24'h000604, 4, 1'b0);
        wait_done(d0 + 1);
        repeat (5) @(negedge clk);
        check_bytes(24'h000604, 4, 1'b0, "R8 continued");
        chk(hdr_n - h == 1, "R8 no new header", hdr_n - h, 1);
        rx_n = 0; d0 = done_n;
        issue(24'h000700, 2, 1'b0);
        wait_done(d0 + 1);
        repeat (5) @(negedge clk);
        check_bytes(24'h000700, 2, 1'b0, "R9 jump");
        chk(hdr_n - h == 2, "R9 new header", hdr_n - h, 2);
        cfg_merge = 1'b0;
        repeat (10) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R11 merge cleared closes", spi_cs_n, 1);
        repeat (10) @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready after close", req_ready, 1);

        chk(bad_op == 0, "R1 opcode", bad_op, 0);
        chk(mosi_bad == 0, "R3 mosi stable while sck high", mosi_bad, 0);
        chk(sck_bad == 0 && sck_rises > 0, "R4 sck high width", sck_bad, 0);
        chk(min_gap >= DIV, "R9 select gap", min_gap, DIV);

        summary();
        $finish;
    end
endmodule